// File: doc/BRIEF.md
# Two-Way Cache Replacement Tracker

This block keeps the tags of a small two-way set-associative cache and nothing else. On each cycle it can take one block-address access. It looks the block up in its set and decides whether the access hits or misses. On a miss it fills a way. If the set is already full, it first picks a victim way and reports which block left. Data, refill timing and write handling are outside the block. A caller uses it to study or drive replacement decisions, and it can read the resident tags and valid bits of every way at any time.

A static mode input picks the policy for choosing a victim in a full set. With the input low, the way touched longest ago is replaced. With the input high, the way touched most recently is replaced. Each set holds a single recency bit that names its most recently touched way. Hits and fills both update that bit. Results are registered and appear one cycle after the access strobe.

Top module: `repl_tracker`

## Requirements
- R1: An access to block address A uses set A mod NUM_SETS and stores tag A / NUM_SETS. Way w of set s is read back on way_valid bit s*2+w and on way_tag bits (s*2+w)*TAG_W upward, where TAG_W = ADDR_W - log2(NUM_SETS).
- R2: An access hits when its set holds a valid way whose tag matches. A hit never evicts and never changes any stored tag or valid bit.
- R3: A miss to a set with an empty way fills the lowest-numbered empty way, so way 0 is filled before way 1, and reports no eviction.
- R4: With mru_mode = 0, a miss to a full set replaces the way that is not the most recently touched one.
- R5: With mru_mode = 1, a miss to a full set replaces the most recently touched way.
- R6: Every hit and every fill makes the touched way the most recently touched way of its set.
- R7: On a replacement, res_evict is 1 and res_evict_addr holds the full block address of the removed block (its stored tag joined with the set index). Otherwise res_evict_addr is 0.
- R8: res_valid, res_hit and res_evict follow the access one clock after acc_valid. A cycle with acc_valid low changes no state and gives all result outputs 0.
- R9: A synchronous reset clears every valid bit, tag, recency bit and result output.
- R10: Under mode 0, the accesses 0,1,2,3,4 all miss, and block 4 evicts block 0.
- R11: Under mode 0, the accesses 0,2,4,8,10,12,14,8,0 give no hits. Under mode 1, the same accesses give exactly one hit, and that hit is the final access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mru_mode | input | 1 | Replacement policy: 0 replaces the least recently touched way, 1 replaces the most recently touched way |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Block address of the access |
| res_valid | output | 1 | A result is present (one cycle after acc_valid) |
| res_hit | output | 1 | The access hit |
| res_evict | output | 1 | The access replaced a resident block |
| res_evict_addr | output | ADDR_W | Block address of the replaced block |
| way_valid | output | NUM_SETS*2 | Valid bit of every way |
| way_tag | output | NUM_SETS*2*TAG_W | Stored tag of every way |

## Verification
The bench builds the tracker with its defaults: two sets and 8-bit block addresses, which gives the four-block cache of the requirements. Directed traffic is kept to the low block numbers, so nearly every access conflicts in a full set, and the recency bit decides the outcome under both modes. Random traffic uses only blocks 0 to 11, with idle gaps between accesses. This covers fills, hits and replacements in both sets.

// File: rtl/repl_pkg.sv
package repl_pkg;

   typedef enum logic {
      POL_LRU = 1'b0,
      POL_MRU = 1'b1
   } repl_pol_e;

   localparam int unsigned WAYS = 2;

   // Choose the way to replace in a full set from its recency bit.
   function automatic logic pick_victim(input logic mru_way, input logic pol);
      if (pol == POL_MRU) return mru_way;
      return ~mru_way;
   endfunction

endpackage

// File: rtl/repl_victim.sv
module repl_victim
   import repl_pkg::*;
(
   input  logic       pol_i,
   input  logic       mru_i,
   input  logic [1:0] valid_i,
   input  logic [1:0] hit_w_i,
   output logic       tgt_o,
   output logic       evict_o
);

   always_comb begin
      tgt_o   = 1'b0;
      evict_o = 1'b0;
      if (|hit_w_i) begin
         tgt_o = hit_w_i[1];
      end else if (!valid_i[0]) begin
         tgt_o = 1'b0;
      end else if (!valid_i[1]) begin
         tgt_o = 1'b1;
      end else begin
         tgt_o   = pick_victim(mru_i, pol_i);
         evict_o = 1'b1;
      end
   end

endmodule

// File: rtl/repl_set.sv
module repl_set
   import repl_pkg::*;
#(
   parameter int unsigned TAG_W = 7
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  sel,
   input  logic                  pol,
   input  logic [TAG_W-1:0]      tag_i,
   output logic                  hit_o,
   output logic                  evict_o,
   output logic [TAG_W-1:0]      evtag_o,
   output logic [1:0]            valid_o,
   output logic [1:0][TAG_W-1:0] tags_o
);

   logic [1:0]            valid_q;
   logic [1:0][TAG_W-1:0] tags_q;
   logic                  mru_q;
   logic [1:0]            hit_w;
   logic                  tgt;
   logic                  evict_c;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_w[w] = valid_q[w] && (tags_q[w] == tag_i);
   end

   repl_victim u_vic (
      .pol_i   (pol),
      .mru_i   (mru_q),
      .valid_i (valid_q),
      .hit_w_i (hit_w),
      .tgt_o   (tgt),
      .evict_o (evict_c)
   );

   assign hit_o   = |hit_w;
   assign evict_o = evict_c;
   assign evtag_o = tags_q[tgt];
   assign valid_o = valid_q;
   assign tags_o  = tags_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
         tags_q  <= '0;
         mru_q   <= 1'b0;
      end else if (sel) begin
         mru_q <= tgt;
         if (!hit_o) begin
            valid_q[tgt] <= 1'b1;
            tags_q[tgt]  <= tag_i;
         end
      end
   end

   assert_fill_order_R3: assert property (@(posedge clk) disable iff (rst)
      valid_q[1] |-> valid_q[0]);
   assert_one_match_R2: assert property (@(posedge clk) disable iff (rst)
      !(hit_w[0] && hit_w[1]));
   assert_hit_keeps_R2: assert property (@(posedge clk) disable iff (rst)
      (sel && hit_o) |=> (valid_q == $past(valid_q)) && (tags_q == $past(tags_q)));
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !sel |=> $stable(valid_q) && $stable(tags_q) && $stable(mru_q));
   assert_lru_pick_R4: assert property (@(posedge clk) disable iff (rst)
      (sel && evict_c && pol == POL_LRU) |-> (tgt != mru_q));
   assert_mru_pick_R5: assert property (@(posedge clk) disable iff (rst)
      (sel && evict_c && pol == POL_MRU) |-> (tgt == mru_q));
   assert_touch_R6: assert property (@(posedge clk) disable iff (rst)
      (sel && hit_o) |=> (mru_q == $past(hit_w[1])));

endmodule

// File: rtl/repl_tracker.sv
module repl_tracker
   import repl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_SETS = 2,
   localparam int unsigned SET_BITS = $clog2(NUM_SETS),
   localparam int unsigned TAG_W    = ADDR_W - SET_BITS
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         mru_mode,
   input  logic                         acc_valid,
   input  logic [ADDR_W-1:0]            acc_addr,
   output logic                         res_valid,
   output logic                         res_hit,
   output logic                         res_evict,
   output logic [ADDR_W-1:0]            res_evict_addr,
   output logic [NUM_SETS*WAYS-1:0]     way_valid,
   output logic [NUM_SETS*WAYS*TAG_W-1:0] way_tag
);

   if (NUM_SETS < 2 || (1 << SET_BITS) != NUM_SETS) begin : g_bad_sets
      $error("repl_tracker: NUM_SETS must be a power of two, at least 2");
   end
   if (ADDR_W <= SET_BITS) begin : g_bad_addr
      $error("repl_tracker: ADDR_W must exceed the set index width");
   end

   logic [SET_BITS-1:0]             set_idx;
   logic [TAG_W-1:0]                acc_tag;
   logic [NUM_SETS-1:0]             s_sel;
   logic [NUM_SETS-1:0]             s_hit;
   logic [NUM_SETS-1:0]             s_evict;
   logic [NUM_SETS-1:0][TAG_W-1:0]  s_evtag;

   assign set_idx = acc_addr[SET_BITS-1:0];
   assign acc_tag = acc_addr[ADDR_W-1:SET_BITS];

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic [1:0]            v;
      logic [1:0][TAG_W-1:0] t;

      assign s_sel[s] = acc_valid && (set_idx == SET_BITS'(s));

      repl_set #(.TAG_W(TAG_W)) u_set (
         .clk     (clk),
         .rst     (rst),
         .sel     (s_sel[s]),
         .pol     (mru_mode),
         .tag_i   (acc_tag),
         .hit_o   (s_hit[s]),
         .evict_o (s_evict[s]),
         .evtag_o (s_evtag[s]),
         .valid_o (v),
         .tags_o  (t)
      );

      assign way_valid[s*WAYS +: WAYS]             = v;
      assign way_tag[s*WAYS*TAG_W +: WAYS*TAG_W]   = t;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid      <= 1'b0;
         res_hit        <= 1'b0;
         res_evict      <= 1'b0;
         res_evict_addr <= '0;
      end else begin
         res_valid      <= acc_valid;
         res_hit        <= acc_valid && s_hit[set_idx];
         res_evict      <= acc_valid && s_evict[set_idx];
         res_evict_addr <= (acc_valid && s_evict[set_idx]) ?
                           {s_evtag[set_idx], set_idx} : '0;
      end
   end

   assert_hit_no_evict_R2: assert property (@(posedge clk) disable iff (rst)
      res_hit |-> !res_evict);
   assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (res_valid == $past(acc_valid)));
   assert_evict_set_R7: assert property (@(posedge clk) disable iff (rst)
      acc_valid |=> (!res_evict ||
         (res_evict_addr[SET_BITS-1:0] == $past(set_idx) &&
          res_evict_addr != $past(acc_addr))));
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !acc_valid |=> !res_hit && !res_evict && res_evict_addr == '0);

endmodule

// File: tb/repl_tracker_tb.sv
module repl_tracker_tb;

   localparam int AW = 8;
   localparam int NS = 2;
   localparam int TW = AW - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              mru_mode = 1'b0;
   logic              acc_valid = 1'b0;
   logic [AW-1:0]     acc_addr = '0;
   logic              res_valid, res_hit, res_evict;
   logic [AW-1:0]     res_evict_addr;
   logic [NS*2-1:0]   way_valid;
   logic [NS*2*TW-1:0] way_tag;

   always #2.5 clk = ~clk;

   repl_tracker #(.ADDR_W(AW), .NUM_SETS(NS)) u_dut (
      .clk(clk), .rst(rst), .mru_mode(mru_mode), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .res_valid(res_valid), .res_hit(res_hit),
      .res_evict(res_evict), .res_evict_addr(res_evict_addr),
      .way_valid(way_valid), .way_tag(way_tag)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // behavioural model: resident block per way (-1 empty), last touch time
   int slot [NS][2];
   int stamp[NS][2];
   int now;
   bit e_valid, e_hit, e_evict;
   int e_eaddr;
   int dut_hits;
   bit last_hit, last_evict;
   int last_eaddr;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < 2; w++) begin
            slot[s][w] = -1;
            stamp[s][w] = 0;
         end
      now = 0;
      e_valid = 0; e_hit = 0; e_evict = 0; e_eaddr = 0;
   endtask

   task automatic model_access(input int a);
      int s, w, tgt;
      s = a % NS;
      now++;
      e_valid = 1; e_hit = 0; e_evict = 0; e_eaddr = 0;
      tgt = -1;
      for (w = 0; w < 2; w++)
         if (slot[s][w] == a) begin e_hit = 1; tgt = w; end
      if (!e_hit) begin
         if (slot[s][0] < 0) tgt = 0;
         else if (slot[s][1] < 0) tgt = 1;
         else begin
            if (mru_mode) tgt = (stamp[s][0] > stamp[s][1]) ? 0 : 1;
            else          tgt = (stamp[s][0] < stamp[s][1]) ? 0 : 1;
            e_evict = 1;
            e_eaddr = slot[s][tgt];
         end
         slot[s][tgt] = a;
      end
      stamp[s][tgt] = now;
   endtask

   task automatic compare_all();
      check(res_valid === e_valid, "R8 res_valid", int'(res_valid), int'(e_valid));
      check(res_hit === e_hit, "R2 res_hit", int'(res_hit), int'(e_hit));
      check(res_evict === e_evict, "R3 res_evict", int'(res_evict), int'(e_evict));
      check(res_evict_addr === AW'(e_eaddr), "R7 res_evict_addr",
            int'(res_evict_addr), e_eaddr);
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < 2; w++) begin
            int ev, et;
            ev = (slot[s][w] >= 0);
            et = ev ? slot[s][w] / NS : 0;
            check(way_valid[s*2+w] === ev[0], "R1 way_valid",
                  int'(way_valid[s*2+w]), ev);
            check(way_tag[(s*2+w)*TW +: TW] === TW'(et), "R1 way_tag",
                  int'(way_tag[(s*2+w)*TW +: TW]), et);
         end
   endtask

   task automatic step(input bit v, input int a);
      acc_valid = v;
      acc_addr  = AW'(a);
      if (v) model_access(a);
      else begin e_valid = 0; e_hit = 0; e_evict = 0; e_eaddr = 0; end
      @(negedge clk);
      compare_all();
      last_hit = res_hit; last_evict = res_evict; last_eaddr = int'(res_evict_addr);
      if (res_hit) dut_hits++;
   endtask

   task automatic do_reset(input bit mode);
      acc_valid = 0;
      rst = 1;
      mru_mode = mode;
      @(negedge clk);
      @(negedge clk);
      rst = 0;
      model_clear();
      dut_hits = 0;
      // R9: everything cleared
      check(way_valid === '0, "R9 valid cleared", int'(way_valid), 0);
      check(way_tag === '0, "R9 tags cleared", int'(way_tag[TW-1:0]), 0);
      check(!res_valid && !res_hit && !res_evict, "R9 outputs cleared",
            int'(res_valid), 0);
   endtask

   task automatic run_conflict(output int hits);
      int seq[9] = '{0, 2, 4, 8, 10, 12, 14, 8, 0};
      dut_hits = 0;
      foreach (seq[i]) step(1, seq[i]);
      hits = dut_hits;
   endtask

   initial begin
      int h;
      @(negedge clk);
      // R10 five-block sequence under mode 0
      do_reset(0);
      for (int a = 0; a < 5; a++) step(1, a);
      check(dut_hits == 0, "R10 hits", dut_hits, 0);
      check(last_evict && last_eaddr == 0, "R10 block 4 evicts 0", last_eaddr, 0);
      // R3: way 0 then way 1 filled in set 0, no eviction before full
      do_reset(0);
      step(1, 0);
      check(!last_evict && way_valid[1:0] == 2'b01, "R3 first fill way 0",
            int'(way_valid[1:0]), 1);
      step(1, 2);
      check(!last_evict && way_valid[1:0] == 2'b11, "R3 second fill way 1",
            int'(way_valid[1:0]), 3);
      // R6/R4: hit on 0 refreshes it, so 4 evicts 2
      step(1, 0);
      check(last_hit == 1, "R6 hit on 0", int'(last_hit), 1);
      step(1, 4);
      check(last_eaddr == 2, "R4 victim after refresh", last_eaddr, 2);
      // R8 idle cycles
      step(0, 5);
      step(0, 7);
      // R11 conflict sequence, both modes
      do_reset(0);
      run_conflict(h);
      check(h == 0, "R11 mode 0 hits", h, 0);
      do_reset(1);
      step(1, 0); step(1, 2); step(1, 4);
      check(last_eaddr == 2, "R5 MRU victim", last_eaddr, 2);
      do_reset(1);
      run_conflict(h);
      check(h == 1, "R11 mode 1 hits", h, 1);
      check(last_hit == 1, "R11 final access hits", int'(last_hit), 1);
      // random traffic in both modes
      for (int m = 0; m < 2; m++) begin
         do_reset(m[0]);
         for (int i = 0; i < 2000; i++)
            step(($urandom % 4) != 0, int'($urandom % 12));
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule